// File: doc/BRIEF.md
# SPI controller with simplex modes

This block is an 8-bit serial peripheral core that can be the clock master or a selected slave on a three-wire SPI link. Software writes a byte into a transmit holding buffer, reads received bytes from a receive holding buffer, and watches three flags: busy, transmit buffer empty and receive buffer full. Only clock mode 0 is supported. In that mode the clock idles low, data changes after a falling edge, data is sampled on a rising edge, and the most significant bit goes first. As master the core makes its own serial clock from the system clock through a compile-time divider. As slave it samples the external clock and select through synchronizers.

Besides normal full-duplex exchange, the core has two simplex arrangements. In single-wire mode, one data pin carries traffic in both directions: the MOSI pin when master, the MISO pin when slave. A direction control decides whether that pin is driven. In receive-only mode, the transmit pin is left undriven. A master in receive-only mode clocks in byte after byte with no write needed, from enable until enable is dropped. It always finishes the byte in progress before it stops.

Each pin has an output value and an output enable, so the pads outside the block can be tri-stated.

Top module: `spi_simplex_core`

## Requirements
- R1: Master full duplex (`master`=1, `bidir`=0, `rx_only`=0). A `wr_en` strobe starts one transfer. The byte is shifted out MSB first on `mosi_o`, which changes only after falling `sck_o` edges. `miso_i` is sampled on each rising edge. After the 8th bit the received byte appears on `rd_data` and `rxne` goes to 1. A `rd_en` strobe clears `rxne`.
- R2: `txe` is 1 after reset. It is 0 in the cycle after a `wr_en` strobe. It returns to 1 in the cycle after the shift register takes the transmit buffer.
- R3: The master clock idles low. Rising edges of `sck_o` are 2*CLK_DIV system cycles apart. `busy` is 1 from the cycle the shift register is loaded until the last bit completes, and 0 when the master is idle.
- R4: Master receive-only (`rx_only`=1, `bidir`=0). Transfers start as soon as `en` is 1, without a write, and continue byte after byte. `busy` stays 1 without a gap while `en` is held. `mosi_oe` stays 0.
- R5: When `en` is cleared in master receive-only mode, the byte in progress still completes into the receive buffer. After that, `sck_o` stops toggling and `busy` falls.
- R6: Master single-wire mode (`bidir`=1). `miso_oe` stays 0. With `bidir_out`=1, `mosi_oe` is 1 and a write transmits on MOSI. With `bidir_out`=0, `mosi_oe` is 0 and bytes are received continuously from `mosi_i`, as in R4 and R5.
- R7: Slave full duplex (`master`=0). While `en`=1 and `nss_i`=0, `miso_oe` is 1 and the MSB of the written byte is on `miso_o` before the first rising edge of `sck_i`. `mosi_i` is sampled on rising edges, and the 8th bit puts the byte in the receive buffer with `rxne`=1. A slave never drives `sck_oe` or `mosi_oe`.
- R8: Slave receive-only. `miso_oe` stays 0, and bytes keep arriving in the receive buffer for as long as `nss_i` is low and `sck_i` toggles.
- R9: After reset, `txe`=1, `rxne`=0, `busy`=0 and `sck_o`=0. With `en`=0, all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Peripheral enable |
| master | input | 1 | 1 = master, 0 = slave |
| bidir | input | 1 | Single data wire mode |
| bidir_out | input | 1 | In single-wire mode, 1 = drive the data pin |
| rx_only | input | 1 | Receive-only mode (used when bidir=0) |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | DW | Byte to transmit |
| rd_en | input | 1 | Data register read strobe, clears rxne |
| rd_data | output | DW | Receive buffer contents |
| busy | output | 1 | Transfer in progress |
| txe | output | 1 | Transmit buffer empty |
| rxne | output | 1 | Receive buffer holds an unread byte |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output value |
| mosi_oe | output | 1 | MOSI pin output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO pin output enable |
| nss_i | input | 1 | Slave select, active low |

## Verification
`txe` falls one system cycle after a write strobe and rises one cycle later, when an idle master loads the shift register. `busy` also rises in that load cycle. The bench samples all three at the falling clock edges that follow. The first rising edge of `sck_o` comes CLK_DIV cycles after the load. Each byte takes 2*CLK_DIV*8 cycles and ends with `rxne` set in the same cycle that `sck_o` falls for the last time. For these reasons the bench paces its partner model on the `sck_o` edges themselves and reads results once `busy` has dropped. A slave sees `sck_i` and `nss_i` two synchronizer stages late, plus one edge-detect register. The bench therefore holds each slave half-period for eight cycles and checks the receive buffer eight cycles after the last falling edge.

// File: rtl/spi_simplex_pkg.sv
package spi_simplex_pkg;

  typedef enum logic {
    M_IDLE = 1'b0,
    M_RUN  = 1'b1
  } mstate_e;

  // Configurations in which nothing is transmitted and the core only listens.
  function automatic logic rx_continuous(input logic bidir, input logic dir_out,
                                         input logic rx_only);
    return bidir ? !dir_out : rx_only;
  endfunction

endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R3: half periods are several cycles long, so ticks never come back to back
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST;
    else        stg[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST;
        else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux (
  input  logic master,
  input  logic en,
  input  logic bidir,
  input  logic bidir_out,
  input  logic rx_only,
  input  logic nss_low,
  input  logic tx_bit,
  input  logic sck_q,
  input  logic m_mosi,
  input  logic m_miso,
  input  logic s_mosi,
  input  logic s_miso,
  output logic din,
  output logic sck_o,
  output logic sck_oe,
  output logic mosi_o,
  output logic mosi_oe,
  output logic miso_o,
  output logic miso_oe
);
  logic drive_tx;

  always_comb begin
    drive_tx = bidir ? bidir_out : !rx_only;
    sck_o    = sck_q;
    sck_oe   = en && master;
    mosi_o   = master ? tx_bit : 1'b0;
    miso_o   = master ? 1'b0 : tx_bit;
    mosi_oe  = master && en && drive_tx;
    miso_oe  = !master && en && nss_low && drive_tx;
    if (master) din = bidir ? m_mosi : m_miso;
    else        din = bidir ? s_miso : s_mosi;
  end
endmodule

// File: rtl/spi_simplex_core.sv
module spi_simplex_core #(
  parameter int DW          = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          master,
  input  logic          bidir,
  input  logic          bidir_out,
  input  logic          rx_only,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          txe,
  output logic          rxne,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          nss_i
);
  import spi_simplex_pkg::*;

  localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] v, input logic b);
    return {v[DW-2:0], b};
  endfunction

  // state
  mstate_e       mstate;
  logic [DW-1:0] tx_buf, rx_buf, sr;
  logic [BCW-1:0] bit_cnt;
  logic          txe_q, rxne_q, sck_q, samp_q, sck_d;
  logic          s_loaded, s_reload;

  // named internal events
  logic          rx_cont, tick, m_run, m_want, m_done, m_load;
  logic          s_active, s_rise, s_fall, s_done, s_load;
  logic          byte_done, load_ev, din;
  logic [DW-1:0] load_val, rx_word;
  logic [3:0]    sync_q;

  assign rx_cont = rx_continuous(bidir, bidir_out, rx_only);

  spi_in_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'b1000)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({nss_i, sck_i, mosi_i, miso_i}),
    .q_o  (sync_q)
  );

  assign m_run = (mstate == M_RUN);

  spi_baud_tick #(.DIV(CLK_DIV)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (master && m_run),
    .tick (tick)
  );

  spi_pin_mux u_mux (
    .master   (master),
    .en       (en),
    .bidir    (bidir),
    .bidir_out(bidir_out),
    .rx_only  (rx_only),
    .nss_low  (!sync_q[3]),
    .tx_bit   (sr[DW-1]),
    .sck_q    (sck_q),
    .m_mosi   (mosi_i),
    .m_miso   (miso_i),
    .s_mosi   (sync_q[1]),
    .s_miso   (sync_q[0]),
    .din      (din),
    .sck_o    (sck_o),
    .sck_oe   (sck_oe),
    .mosi_o   (mosi_o),
    .mosi_oe  (mosi_oe),
    .miso_o   (miso_o),
    .miso_oe  (miso_oe)
  );

  assign s_active  = en && !master && !sync_q[3];
  assign s_rise    = sync_q[2] && !sck_d;
  assign s_fall    = !sync_q[2] && sck_d;

  assign m_want    = en && master && (rx_cont || !txe_q);
  assign m_done    = master && m_run && tick && sck_q && (bit_cnt == LAST_BIT);
  assign m_load    = master && (m_run ? (m_done && m_want) : m_want);
  assign s_done    = s_active && s_loaded && s_rise && (bit_cnt == LAST_BIT);
  assign s_load    = s_active && (!s_loaded || (s_fall && s_reload));
  assign byte_done = m_done || s_done;
  assign load_ev   = m_load || s_load;
  assign load_val  = rx_cont ? '0 : tx_buf;
  assign rx_word   = shift_in(sr, master ? samp_q : din);

  assign rd_data = rx_buf;
  assign txe     = txe_q;
  assign rxne    = rxne_q;
  assign busy    = master ? m_run : s_active;

  // buffers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0;
      rx_buf <= '0;
      txe_q  <= 1'b1;
      rxne_q <= 1'b0;
      sck_d  <= 1'b0;
    end else begin
      sck_d <= sync_q[2];
      if (wr_en)                   tx_buf <= wr_data;
      if (wr_en)                   txe_q  <= 1'b0;
      else if (load_ev && !rx_cont) txe_q <= 1'b1;
      if (byte_done)               rx_buf <= rx_word;
      if (byte_done)               rxne_q <= 1'b1;
      else if (rd_en)              rxne_q <= 1'b0;
    end
  end

  // shift engine, master and slave
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstate   <= M_IDLE;
      sr       <= '0;
      bit_cnt  <= '0;
      sck_q    <= 1'b0;
      samp_q   <= 1'b0;
      s_loaded <= 1'b0;
      s_reload <= 1'b0;
    end else if (master) begin
      s_loaded <= 1'b0;
      s_reload <= 1'b0;
      if (!m_run) begin
        sck_q <= 1'b0;
        if (m_want) begin
          mstate  <= M_RUN;
          sr      <= load_val;
          bit_cnt <= '0;
        end
      end else if (tick) begin
        if (!sck_q) begin
          sck_q  <= 1'b1;
          samp_q <= din;
        end else begin
          sck_q <= 1'b0;
          if (bit_cnt == LAST_BIT) begin
            if (m_want) begin
              sr      <= load_val;
              bit_cnt <= '0;
            end else begin
              mstate <= M_IDLE;
            end
          end else begin
            sr      <= shift_in(sr, samp_q);
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end else begin
      mstate <= M_IDLE;
      sck_q  <= 1'b0;
      if (!s_active) begin
        s_loaded <= 1'b0;
        s_reload <= 1'b0;
        bit_cnt  <= '0;
      end else if (!s_loaded) begin
        sr       <= load_val;
        s_loaded <= 1'b1;
        bit_cnt  <= '0;
      end else if (s_rise) begin
        samp_q <= din;
        if (bit_cnt == LAST_BIT) s_reload <= 1'b1;
      end else if (s_fall) begin
        if (s_reload) begin
          sr       <= load_val;
          bit_cnt  <= '0;
          s_reload <= 1'b0;
        end else begin
          sr      <= shift_in(sr, samp_q);
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R1: a completed byte lands in the receive buffer with the flag set
  p_done_rxne_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (rxne && rd_data == $past(rx_word)));

  // R2: a write empties nothing; it marks the buffer full next cycle
  p_wr_txe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !txe);

  // R2: the shift register taking the buffer empties it
  p_load_txe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !rx_cont && !wr_en) |=> txe);

  // R3: an idle master holds the clock low
  p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> !sck_o);

  // R4: continuous reception never leaves the run state while enabled
  p_rxonly_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master && m_run && rx_cont && en) |=> m_run);

  // R5: the master stops only on a byte boundary
  p_stop_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $fell(m_run)) |-> $past(m_done));

  // R6: single-wire master leaves MISO alone
  p_bidir_miso_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master && bidir) |-> !miso_oe);

  // R8: slave receive-only never drives MISO
  p_rxonly_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !bidir && rx_only) |-> !miso_oe);
endmodule

// File: tb/sim_spi_simplex_core.sv
`timescale 1ns/1ps
module sim_spi_simplex_core;
  localparam int DW = 8;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, master = 1'b1, bidir = 1'b0, bidir_out = 1'b0, rx_only = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic busy, txe, rxne;
  logic sck_i = 1'b0, nss_i = 1'b1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic p_bit = 1'b0, bb_mosi = 1'b0, slave_drv = 1'b0;
  logic mosi_i, miso_i;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  assign mosi_i = slave_drv ? bb_mosi : p_bit;
  assign miso_i = p_bit;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_simplex_core #(.DW(DW), .CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .bidir(bidir),
    .bidir_out(bidir_out), .rx_only(rx_only), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .txe(txe), .rxne(rxne),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .nss_i(nss_i)
  );

  // {byte written, byte returned by partner}
  localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_busy_low();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // master transfer started by a write; partner returns pbyte
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] pbyte,
                             input bit check_rx, input bit check_period);
    logic [7:0] cap;
    int t0, t1;
    cap = '0; t0 = 0; t1 = 0;
    p_bit = pbyte[7];
    wr_data = tx;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 txe low after write", txe, 1'b0);
    @(negedge clk);
    chk("R2 txe high after load", txe, 1'b1);
    chk("R3 busy after load", busy, 1'b1);
    for (int i = 0; i < 8; i++) begin
      p_bit = pbyte[7-i];
      @(posedge sck_o);
      cap = {cap[6:0], mosi_o};
      if (i == 0) t0 = cyc;
      if (i == 1) t1 = cyc;
      @(negedge sck_o);
    end
    @(negedge clk);
    wait_busy_low();
    if (check_period) chk("R3 sck period", t1 - t0, 2 * CLK_DIV);
    chk("R1 mosi byte MSB first", cap, tx);
    chk("R3 busy low after byte", busy, 1'b0);
    chk("R1 rxne set", rxne, 1'b1);
    if (check_rx) chk("R1 received byte", rd_data, pbyte);
    read_pulse();
    chk("R1 rxne cleared by read", rxne, 1'b0);
  endtask

  // continuous master reception of a stream; en drops inside the last byte
  task automatic master_stream(input logic [31:0] stream, input int nbytes, input string tag);
    int gaps;
    gaps = 0;
    p_bit = stream[31];
    en = 1'b1;
    fork
      begin
        for (int i = 0; i < nbytes * 8; i++) begin
          p_bit = stream[31-i];
          @(posedge sck_o);
          @(negedge sck_o);
        end
      end
      begin
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < nbytes - 1; k++) begin
          for (int w = 0; w < 400 && !rxne; w++) begin
            @(negedge clk);
            if (!busy) gaps++;
            if (mosi_oe) gaps++;
          end
          chk({tag, " stream byte"}, rd_data, stream[31-8*k -: 8]);
          read_pulse();
        end
        repeat (20) @(negedge clk);
        chk({tag, " busy continuous, mosi undriven"}, gaps, 0);
        en = 1'b0;
        wait_busy_low();
        chk("R5 last byte completed", rxne, 1'b1);
        chk("R5 last byte value", rd_data, stream[31-8*(nbytes-1) -: 8]);
        read_pulse();
      end
    join
    begin
      int rises;
      rises = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (sck_o) rises++;
      end
      chk("R5 sck stopped, busy low", {rises[15:0], 15'd0, busy}, 32'd0);
    end
  endtask

  task automatic slave_byte(input logic [7:0] d, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      bb_mosi = d[7-i];
      repeat (8) @(negedge clk);
      sck_i = 1'b1;
      got = {got[6:0], miso_o};
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset flags", {txe, rxne, busy, sck_o}, 4'b1000);
    chk("R9 enables off", {sck_oe, mosi_oe, miso_oe}, 3'b000);

    // R1 full duplex through the vector table
    en = 1'b1;
    @(negedge clk);
    chk("R1 master drives sck and mosi", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    for (int v = 0; v < 4; v++) begin
      master_xfer(VEC[v][15:8], VEC[v][7:0], 1'b1, v == 0);
      repeat (5) @(negedge clk);
    end

    // R4 / R5 master receive-only
    en = 1'b0;
    rx_only = 1'b1;
    @(negedge clk);
    master_stream(32'hC35AF00F, 3, "R4");

    // R6 single wire, transmit direction
    rx_only = 1'b0;
    bidir = 1'b1;
    bidir_out = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk("R6 tx dir enables", {mosi_oe, miso_oe}, 2'b10);
    master_xfer(8'h6B, 8'h00, 1'b0, 1'b0);

    // R6 single wire, receive direction
    en = 1'b0;
    bidir_out = 1'b0;
    @(negedge clk);
    fork
      begin
        @(negedge clk);
        @(negedge clk);
        chk("R6 rx dir enables", {mosi_oe, miso_oe, busy}, 3'b001);
      end
    join_none
    master_stream(32'h9D2E0000, 2, "R6");
    bidir = 1'b0;

    // R7 slave full duplex
    master = 1'b0;
    en = 1'b1;
    slave_drv = 1'b1;
    @(negedge clk);
    wr_data = 8'h96;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 slave quiet when unselected", {sck_oe, mosi_oe, miso_oe, busy}, 4'b0000);
    nss_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7 selected: miso driven, busy, loaded", {miso_oe, busy, txe, sck_oe, mosi_oe}, 5'b11100);
    slave_byte(8'h4D, got);
    repeat (8) @(negedge clk);
    chk("R7 miso byte", got, 8'h96);
    chk("R7 rxne", rxne, 1'b1);
    chk("R7 received byte", rd_data, 8'h4D);
    read_pulse();
    nss_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 released", {miso_oe, busy}, 2'b00);

    // R8 slave receive-only
    rx_only = 1'b1;
    nss_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 miso undriven", {miso_oe, busy}, 2'b01);
    slave_byte(8'h31, got);
    repeat (8) @(negedge clk);
    chk("R8 first byte", {7'd0, rxne, rd_data}, {7'd0, 1'b1, 8'h31});
    read_pulse();
    slave_byte(8'hE7, got);
    repeat (8) @(negedge clk);
    chk("R8 second byte", {7'd0, rxne, rd_data}, {7'd0, 1'b1, 8'hE7});
    chk("R8 miso still undriven", miso_oe, 1'b0);
    nss_i = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule